// File: doc/BRIEF.md
# Unverified Cache Line Tracker

This block holds the verification state for every line of a small set-associative L1 data cache used by one core of a redundant-execution pair. For each line it keeps four bits: valid, dirty, unverified (the line holds results not yet confirmed by a fingerprint comparison) and peer-sourced (the line arrived from another cache by a cache-to-cache transfer). Tag and data arrays live elsewhere; the cache controller reports write hits, fills and eviction requests, and the comparison logic reports match or mismatch events.

An unverified line is locked: it may not leave the cache. Eviction picks an unlocked way with a per-set round-robin pointer, tells the controller whether the victim must be written back, and asks for a synchronisation when every way of the set is locked. The first write to a verified dirty line raises a forced write-back so the next level keeps a verified copy. A match releases all locks in one cycle; a mismatch squashes every unverified line in one cycle and reports which lines were dropped. A lookup port lets the controller read a line's unverified and peer-sourced bits, for example to pass the unverified bit along when it supplies a line to another cache.

Top module: `uvt_tracker`

## Requirements
- R1: A write hit (wr_hit=1) in a cycle without fp_match or fp_mismatch makes the addressed line unverified and dirty from the next cycle; writing a line that is already unverified raises no wb_force.
- R2: wb_force is 1 in the same cycle as a write hit exactly when the addressed line is valid, dirty and not unverified, and there is no fp_match or fp_mismatch that cycle.
- R3: An eviction grant never names an unverified way; evict_wb is 1 when the chosen victim is valid and dirty; the victim line is invalid (clean, not peer-sourced) from the next cycle.
- R4: Each set has a way pointer that is 0 after reset; the victim is the first non-unverified way found searching upward from the pointer with wrap-around, and after a grant the pointer becomes victim way + 1 modulo WAYS.
- R5: When an eviction is requested and every way of the set is unverified, sync_req=1 and evict_grant=0 in that cycle, and no line state or pointer changes.
- R6: A fill sets the line valid, its unverified bit and dirty bit to fill_unv, and its peer-sourced bit to fill_c2c.
- R7: fp_match clears the unverified and peer-sourced bits of every line in one cycle, leaving valid and dirty bits unchanged.
- R8: fp_mismatch gives inval_vld=1 in the same cycle and inval_map bit (set*WAYS+way) equal to that line's unverified bit; from the next cycle those lines are invalid, clean, verified and not peer-sourced, while other lines are unchanged. fp_mismatch takes priority over fp_match.
- R9: In a cycle with fp_match or fp_mismatch, write hits, fills and eviction requests are ignored: wb_force, evict_grant, evict_wb and sync_req are 0 and they change no state.
- R10: ld_unv and ld_c2c show, in the same cycle, the unverified and peer-sourced bits of the line selected by ld_set and ld_way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_hit | input | 1 | Store hit to a line |
| wr_set | input | $clog2(SETS) | Set of the written line |
| wr_way | input | $clog2(WAYS) | Way of the written line |
| wb_force | output | 1 | Write the line's verified contents to the next level first |
| fill_vld | input | 1 | Line fill |
| fill_set | input | $clog2(SETS) | Set of the filled line |
| fill_way | input | $clog2(WAYS) | Way of the filled line |
| fill_c2c | input | 1 | Fill came from another cache |
| fill_unv | input | 1 | Supplied line was unverified at the source |
| evict_req | input | 1 | Replacement needed |
| evict_set | input | $clog2(SETS) | Set needing a victim |
| evict_grant | output | 1 | Victim chosen |
| evict_way | output | $clog2(WAYS) | Chosen victim way |
| evict_wb | output | 1 | Victim must be written back |
| sync_req | output | 1 | All ways locked; request fingerprint comparison |
| fp_match | input | 1 | Fingerprints agreed |
| fp_mismatch | input | 1 | Fingerprints disagreed |
| inval_vld | output | 1 | Bulk invalidate command |
| inval_map | output | SETS*WAYS | Lines invalidated, bit set*WAYS+way |
| ld_set | input | $clog2(SETS) | Lookup set |
| ld_way | input | $clog2(WAYS) | Lookup way |
| ld_unv | output | 1 | Looked-up line is unverified |
| ld_c2c | output | 1 | Looked-up line is peer-sourced |

## Verification
On every cycle the assertions check that a write leaves its line locked, that a forced write-back only accompanies a write, that a granted victim is never locked, that peer-sourced lines are always valid, and that match and mismatch leave no locked line behind, the latter also dropping every line that was locked. Only the bench's scenarios show the round-robin order and its skipping of locked ways, the sync request on a fully locked set with the state left intact, the write-back flags on victims, the exact invalidate map, and that writes and evictions arriving together with a comparison event are discarded.

// File: rtl/uvt_pkg.sv
package uvt_pkg;
  // Flat position of a line in the state vectors.
  function automatic int lidx(int set_i, int way_i, int ways);
    return set_i * ways + way_i;
  endfunction

  // Way reached by stepping 'step' places upward from 'base', wrapping.
  function automatic int rr_way(int base, int step, int ways);
    return (base + step) % ways;
  endfunction
endpackage

// File: rtl/uvt_victim_sel.sv
module uvt_victim_sel #(
  parameter int WAYS = 4,
  localparam int WW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] elig,
  input  logic [WW-1:0]   ptr,
  output logic            found,
  output logic [WW-1:0]   way
);
  always_comb begin
    found = |elig;
    way   = '0;
    // Walk from the farthest candidate back to the pointer; the nearest wins.
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (elig[uvt_pkg::rr_way(int'(ptr), i, WAYS)])
        way = WW'(uvt_pkg::rr_way(int'(ptr), i, WAYS));
    end
  end
endmodule

// File: rtl/uvt_state_array.sv
module uvt_state_array #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int LINES = SETS * WAYS,
  localparam int LW = $clog2(LINES),
  localparam int SW = $clog2(SETS),
  localparam int WW = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_wr,
  input  logic [LW-1:0]     wr_idx,
  input  logic              do_fill,
  input  logic [LW-1:0]     fill_idx,
  input  logic              fill_c2c,
  input  logic              fill_unv,
  input  logic              do_evict,
  input  logic [LW-1:0]     ev_idx,
  input  logic [SW-1:0]     ev_set,
  input  logic [WW-1:0]     ev_next_ptr,
  input  logic              bulk_release,
  input  logic              bulk_squash,
  output logic [LINES-1:0]  valid_flat,
  output logic [LINES-1:0]  dirty_flat,
  output logic [LINES-1:0]  unv_flat,
  output logic [LINES-1:0]  c2c_flat,
  output logic [SETS*WW-1:0] ptr_flat
);
  logic [LINES-1:0] v_q, d_q, u_q, c_q;
  logic [SETS*WW-1:0] p_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0; d_q <= '0; u_q <= '0; c_q <= '0; p_q <= '0;
    end else if (bulk_squash) begin
      v_q <= v_q & ~u_q;
      d_q <= d_q & ~u_q;
      c_q <= c_q & ~u_q;
      u_q <= '0;
    end else if (bulk_release) begin
      u_q <= '0;
      c_q <= '0;
    end else begin
      // Later updates override earlier ones on the same line.
      if (do_evict) begin
        v_q[ev_idx] <= 1'b0;
        d_q[ev_idx] <= 1'b0;
        c_q[ev_idx] <= 1'b0;
        p_q[int'(ev_set)*WW +: WW] <= ev_next_ptr;
      end
      if (do_fill) begin
        v_q[fill_idx] <= 1'b1;
        d_q[fill_idx] <= fill_unv;
        u_q[fill_idx] <= fill_unv;
        c_q[fill_idx] <= fill_c2c;
      end
      if (do_wr) begin
        u_q[wr_idx] <= 1'b1;
        d_q[wr_idx] <= 1'b1;
      end
    end
  end

  assign valid_flat = v_q;
  assign dirty_flat = d_q;
  assign unv_flat   = u_q;
  assign c2c_flat   = c_q;
  assign ptr_flat   = p_q;

  // R6: a peer-sourced mark never outlives the line it belongs to
  a_r6_c2c_within_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (c_q & ~v_q) == '0)
    else $error("peer-sourced bit on an invalid line");
endmodule

// File: rtl/uvt_tracker.sv
module uvt_tracker #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int LINES = SETS * WAYS,
  localparam int LW = $clog2(LINES),
  localparam int SW = $clog2(SETS),
  localparam int WW = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [SW-1:0]    wr_set,
  input  logic [WW-1:0]    wr_way,
  output logic             wb_force,
  input  logic             fill_vld,
  input  logic [SW-1:0]    fill_set,
  input  logic [WW-1:0]    fill_way,
  input  logic             fill_c2c,
  input  logic             fill_unv,
  input  logic             evict_req,
  input  logic [SW-1:0]    evict_set,
  output logic             evict_grant,
  output logic [WW-1:0]    evict_way,
  output logic             evict_wb,
  output logic             sync_req,
  input  logic             fp_match,
  input  logic             fp_mismatch,
  output logic             inval_vld,
  output logic [LINES-1:0] inval_map,
  input  logic [SW-1:0]    ld_set,
  input  logic [WW-1:0]    ld_way,
  output logic             ld_unv,
  output logic             ld_c2c
);
  // Named internal events
  logic             bulk_evt;
  logic [LW-1:0]    wr_idx, fill_idx, ev_idx, ld_idx;
  logic [LINES-1:0] valid_flat, dirty_flat, unv_flat, c2c_flat;
  logic [SETS*WW-1:0] ptr_flat;
  logic [WW-1:0]    set_ptr, victim_way;
  logic [WAYS-1:0]  elig;
  logic             victim_found;
  logic             wr_go, fill_go, evict_go;

  assign bulk_evt = fp_match | fp_mismatch;
  assign wr_idx   = LW'(uvt_pkg::lidx(int'(wr_set), int'(wr_way), WAYS));
  assign fill_idx = LW'(uvt_pkg::lidx(int'(fill_set), int'(fill_way), WAYS));
  assign ld_idx   = LW'(uvt_pkg::lidx(int'(ld_set), int'(ld_way), WAYS));
  assign ev_idx   = LW'(uvt_pkg::lidx(int'(evict_set), int'(victim_way), WAYS));
  assign set_ptr  = ptr_flat[int'(evict_set)*WW +: WW];

  // A way may be replaced only when it is not locked.
  for (genvar w = 0; w < WAYS; w++) begin : g_elig
    assign elig[w] = ~unv_flat[uvt_pkg::lidx(int'(evict_set), w, WAYS)];
  end

  uvt_victim_sel #(.WAYS(WAYS)) u_sel (
    .elig  (elig),
    .ptr   (set_ptr),
    .found (victim_found),
    .way   (victim_way)
  );

  assign wr_go    = wr_hit & ~bulk_evt;
  assign fill_go  = fill_vld & ~bulk_evt;
  assign evict_go = evict_req & ~bulk_evt & victim_found;

  assign wb_force    = wr_go & valid_flat[wr_idx] & dirty_flat[wr_idx] & ~unv_flat[wr_idx];
  assign evict_grant = evict_go;
  assign evict_way   = victim_way;
  assign evict_wb    = evict_go & valid_flat[ev_idx] & dirty_flat[ev_idx];
  assign sync_req    = evict_req & ~bulk_evt & ~victim_found;
  assign inval_vld   = fp_mismatch;
  assign inval_map   = fp_mismatch ? unv_flat : '0;
  assign ld_unv      = unv_flat[ld_idx];
  assign ld_c2c      = c2c_flat[ld_idx];

  uvt_state_array #(.SETS(SETS), .WAYS(WAYS)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .do_wr        (wr_go),
    .wr_idx       (wr_idx),
    .do_fill      (fill_go),
    .fill_idx     (fill_idx),
    .fill_c2c     (fill_c2c),
    .fill_unv     (fill_unv),
    .do_evict     (evict_go),
    .ev_idx       (ev_idx),
    .ev_set       (evict_set),
    .ev_next_ptr  (victim_way + WW'(1)),
    .bulk_release (fp_match),
    .bulk_squash  (fp_mismatch),
    .valid_flat   (valid_flat),
    .dirty_flat   (dirty_flat),
    .unv_flat     (unv_flat),
    .c2c_flat     (c2c_flat),
    .ptr_flat     (ptr_flat)
  );

  // R1: an accepted write leaves its line locked
  a_r1_write_locks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> unv_flat[$past(wr_idx)])
    else $error("written line not locked");

  // R2: a forced write-back only accompanies a write hit
  a_r2_force_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    wb_force |-> (wr_hit && !bulk_evt))
    else $error("forced write-back without write");

  // R3: the chosen victim is never a locked way
  a_r3_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    evict_grant |-> !unv_flat[ev_idx])
    else $error("locked way granted for eviction");

  // R7: a match leaves no line locked or peer-sourced
  a_r7_match_releases: assert property (@(posedge clk) disable iff (!rst_n)
    fp_match |=> (unv_flat == '0 && c2c_flat == '0))
    else $error("lock survived a match");

  // R8: a mismatch drops every line that was locked
  a_r8_mismatch_squashes: assert property (@(posedge clk) disable iff (!rst_n)
    fp_mismatch |=> (unv_flat == '0 && (valid_flat & $past(unv_flat)) == '0))
    else $error("locked line survived a mismatch");
endmodule

// File: tb/tb_uvt_tracker.sv
module tb_uvt_tracker;
  localparam int SETS = 4;
  localparam int WAYS = 4;
  localparam int LINES = SETS * WAYS;
  localparam int SW = $clog2(SETS);
  localparam int WW = $clog2(WAYS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_hit = 0, fill_vld = 0, fill_c2c = 0, fill_unv = 0, evict_req = 0;
  logic fp_match = 0, fp_mismatch = 0;
  logic [SW-1:0] wr_set = '0, fill_set = '0, evict_set = '0, ld_set = '0;
  logic [WW-1:0] wr_way = '0, fill_way = '0, ld_way = '0;
  logic wb_force, evict_grant, evict_wb, sync_req, inval_vld, ld_unv, ld_c2c;
  logic [WW-1:0] evict_way;
  logic [LINES-1:0] inval_map;

  always #10 clk = ~clk;  // 50 MHz

  uvt_tracker #(.SETS(SETS), .WAYS(WAYS)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_hit(wr_hit), .wr_set(wr_set), .wr_way(wr_way), .wb_force(wb_force),
    .fill_vld(fill_vld), .fill_set(fill_set), .fill_way(fill_way),
    .fill_c2c(fill_c2c), .fill_unv(fill_unv),
    .evict_req(evict_req), .evict_set(evict_set), .evict_grant(evict_grant),
    .evict_way(evict_way), .evict_wb(evict_wb), .sync_req(sync_req),
    .fp_match(fp_match), .fp_mismatch(fp_mismatch),
    .inval_vld(inval_vld), .inval_map(inval_map),
    .ld_set(ld_set), .ld_way(ld_way), .ld_unv(ld_unv), .ld_c2c(ld_c2c)
  );

  // Scoreboard item: which output, its expected value, and the requirement.
  typedef struct { string req; int sig; longint exp; } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // Bench model of the line state
  bit m_v[LINES], m_d[LINES], m_u[LINES], m_c[LINES];
  int m_ptr[SETS];

  function automatic longint actual(int sig);
    case (sig)
      0: return longint'(wb_force);
      1: return longint'(evict_grant);
      2: return longint'(evict_way);
      3: return longint'(evict_wb);
      4: return longint'(sync_req);
      5: return longint'(inval_vld);
      6: return longint'(inval_map);
      7: return longint'(ld_unv);
      default: return longint'(ld_c2c);
    endcase
  endfunction

  function automatic void expect_val(string req, int sig, longint e);
    exp_t it;
    it.req = req; it.sig = sig; it.exp = e;
    sb.push_back(it);
  endfunction

  // Monitor: compares mid-cycle, well away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        checks++;
        if (actual(it.sig) !== it.exp) begin
          errors++;
          $display("FAIL %s signal %0d actual %0h expected %0h", it.req, it.sig,
                   actual(it.sig), it.exp);
        end
      end
    end
  end

  task automatic idle_inputs();
    wr_hit = 0; fill_vld = 0; evict_req = 0; fp_match = 0; fp_mismatch = 0;
    fill_c2c = 0; fill_unv = 0;
  endtask

  task automatic probe(int s, int w, string req);
    @(negedge clk);
    idle_inputs();
    ld_set = SW'(s); ld_way = WW'(w);
    expect_val(req, 7, longint'(m_u[s*WAYS+w]));
    expect_val(req, 8, longint'(m_c[s*WAYS+w]));
  endtask

  task automatic do_write(int s, int w, string req);
    int k;
    k = s * WAYS + w;
    @(negedge clk);
    idle_inputs();
    wr_hit = 1; wr_set = SW'(s); wr_way = WW'(w);
    expect_val(req, 0, longint'(m_v[k] && m_d[k] && !m_u[k]));
    m_u[k] = 1; m_d[k] = 1;
  endtask

  task automatic do_fill(int s, int w, bit c2c, bit unv);
    int k;
    k = s * WAYS + w;
    @(negedge clk);
    idle_inputs();
    fill_vld = 1; fill_set = SW'(s); fill_way = WW'(w);
    fill_c2c = c2c; fill_unv = unv;
    m_v[k] = 1; m_d[k] = unv; m_u[k] = unv; m_c[k] = c2c;
  endtask

  task automatic do_evict(int s, string req);
    int pick;
    pick = -1;
    for (int i = 0; i < WAYS; i++) begin
      int cw;
      cw = (m_ptr[s] + i) % WAYS;
      if (pick < 0 && !m_u[s*WAYS+cw]) pick = cw;
    end
    @(negedge clk);
    idle_inputs();
    evict_req = 1; evict_set = SW'(s);
    if (pick < 0) begin
      expect_val(req, 1, 0);
      expect_val(req, 4, 1);
    end else begin
      int k;
      k = s * WAYS + pick;
      expect_val(req, 1, 1);
      expect_val(req, 4, 0);
      expect_val(req, 2, pick);
      expect_val(req, 3, longint'(m_v[k] && m_d[k]));
      m_v[k] = 0; m_d[k] = 0; m_c[k] = 0;
      m_ptr[s] = (pick + 1) % WAYS;
    end
  endtask

  // Comparison event, optionally with a write and an eviction riding along.
  task automatic do_bulk(bit m, bit mm, bit with_wr, int ws, int ww, bit with_ev, int es,
                         string req);
    longint map;
    map = 0;
    for (int k = 0; k < LINES; k++) if (m_u[k]) map |= (longint'(1) << k);
    @(negedge clk);
    idle_inputs();
    fp_match = m; fp_mismatch = mm;
    wr_hit = with_wr; wr_set = SW'(ws); wr_way = WW'(ww);
    evict_req = with_ev; evict_set = SW'(es);
    expect_val(req, 5, longint'(mm));
    expect_val(req, 6, mm ? map : 0);
    expect_val("R9", 0, 0);
    expect_val("R9", 1, 0);
    expect_val("R9", 3, 0);
    expect_val("R9", 4, 0);
    for (int k = 0; k < LINES; k++) begin
      if (mm) begin
        if (m_u[k]) begin m_v[k] = 0; m_d[k] = 0; m_c[k] = 0; end
        m_u[k] = 0;
      end else begin
        m_u[k] = 0; m_c[k] = 0;
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) m_ptr[s] = 0;
    for (int k = 0; k < LINES; k++) begin m_v[k] = 0; m_d[k] = 0; m_u[k] = 0; m_c[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // Reset state (R10) and pointer starting at way 0 (R4)
    probe(0, 0, "R10");
    do_evict(0, "R4");

    // Fills: peer-sourced verified, and unverified supplied line (R6)
    do_fill(1, 2, 1, 0);
    probe(1, 2, "R6");
    do_fill(1, 3, 0, 1);
    probe(1, 3, "R6");

    // Writes: clean line gives no force; repeat write on locked line none (R1, R2)
    do_write(1, 2, "R2");
    do_write(1, 2, "R1");
    probe(1, 2, "R1");

    // Match releases; next write to verified dirty line is forced (R7, R2)
    do_bulk(1, 0, 0, 0, 0, 0, 0, "R7");
    probe(1, 2, "R7");
    probe(1, 3, "R7");
    do_write(1, 2, "R2");

    // Evictions in set 1 walk past the locked way 2 and flag dirty victims (R3, R4)
    do_evict(1, "R4");
    do_evict(1, "R4");
    do_evict(1, "R3");
    do_evict(1, "R3");

    // Fully locked set requests sync and keeps state (R5)
    for (int w = 0; w < WAYS; w++) do_fill(2, w, w[0], 1);
    do_evict(2, "R5");
    probe(2, 1, "R5");
    do_evict(2, "R5");

    // Round-robin skipping a locked way (R4)
    do_fill(3, 1, 0, 1);
    do_evict(3, "R4");
    do_evict(3, "R4");
    do_evict(3, "R4");

    // Match with write and eviction riding along: both ignored (R9)
    do_fill(0, 1, 0, 0);
    do_bulk(1, 0, 1, 0, 1, 1, 0, "R7");
    probe(0, 1, "R9");

    // Mismatch squashes locked lines, keeps verified ones (R8)
    do_fill(0, 2, 1, 1);
    do_write(3, 1, "R1");
    do_write(0, 1, "R2");
    do_bulk(0, 1, 0, 0, 0, 0, 0, "R8");
    probe(0, 2, "R8");
    probe(2, 3, "R8");
    do_evict(2, "R8");

    // Mismatch wins over match in the same cycle (R8)
    do_fill(3, 3, 0, 1);
    do_bulk(1, 1, 1, 3, 0, 0, 0, "R8");
    do_evict(3, "R8");
    probe(3, 0, "R9");

    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    #8;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule